// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block watches a single external event pin and, when that pin shows a clean qualifying transition, freezes a copy of the running time and date together with two supply-status bits. The live seconds, minutes, hours, day, month and year arrive on one packed bus from the timekeeping logic. A qualifying event also raises an event flag. When interrupts are enabled, that flag asks for the shared active-low interrupt line to be pulled down.

The pin is first brought into the clock domain by a synchronizer chain. It then passes a debounce filter whose length is set at run time, and only after that does an edge detector act on it. The first stamp is kept until software clears the flag, so a burst of later events cannot overwrite it. Software controls the block through write strobes: one for the capture enable, one for the interrupt enable, and one that clears the flag. The interrupt request is an enable for an external open-drain pull-down.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset, evt_flag, irq_pull_low, cap_time, cap_vlow and cap_vdet are all 0, and both the capture enable and the interrupt enable are off.
- R2: A rising transition of evt_in that stays stable for filt_len+1 synchronized cycles sets evt_flag. With filt_len = 0 the flag reads 1 after the 4th rising clock edge that follows the change of evt_in, and still reads 0 after the 3rd.
- R3: When the capture enable is 1 and evt_flag is 0, a valid event loads live_time into cap_time, stat_vlow into cap_vlow and stat_vdet into cap_vdet. The field layout is seconds in bits 7:0, minutes in 15:8, hours in 23:16, day in 31:24, month in 39:32 and year in 47:40. cap_time changes only on a valid event.
- R4: When the capture enable is 0, a valid event still sets evt_flag but leaves cap_time, cap_vlow and cap_vdet unchanged.
- R5: A high pulse on evt_in shorter than filt_len+1 synchronized cycles is rejected and does not set evt_flag.
- R6: While evt_flag is 1 and no clear is written, later valid events leave the capture registers unchanged.
- R7: irq_pull_low is 1 exactly when evt_flag is 1 and the interrupt enable is 1. With the interrupt enable at 0 it stays 0 while the flag is set.
- R8: Writing 0 to the interrupt enable, or pulsing flag_clr, drives irq_pull_low to 0 after the next clock edge.
- R9: A valid event in the same cycle as flag_clr wins: it captures the new time (if capture is enabled) and leaves evt_flag at 1.
- R10: With the default edge mode, a falling transition of evt_in does not set evt_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Raw external event pin |
| filt_len | input | 4 | Debounce length; stable cycles needed = filt_len+1 |
| live_time | input | 48 | Running time and date fields, packed as in R3 |
| stat_vlow | input | 1 | Live voltage-low status bit |
| stat_vdet | input | 1 | Live voltage-detect status bit |
| wr_cap_en | input | 1 | Write strobe for the capture enable |
| cap_en_val | input | 1 | Value written to the capture enable |
| wr_irq_en | input | 1 | Write strobe for the interrupt enable |
| irq_en_val | input | 1 | Value written to the interrupt enable |
| flag_clr | input | 1 | Writes 0 to the event flag |
| cap_time | output | 48 | Captured time and date fields |
| cap_vlow | output | 1 | Captured copy of the voltage-low bit |
| cap_vdet | output | 1 | Captured copy of the voltage-detect bit |
| evt_flag | output | 1 | Event flag |
| irq_pull_low | output | 1 | 1 = drive the shared interrupt line low |

## Verification
The assertions check every cycle that the captured stamp moves only on a filtered event pulse and stays frozen while the flag is held. They also check that a rise of the flag always follows such a pulse, and that a clear or an interrupt-enable write of 0 releases the interrupt line one edge later. What only the bench scenarios can show is the debounce behaviour at the ports: the exact latency from pin to flag, the rejection of short glitches, and the blindness to falling edges. The bench also shows the captured field values under several time patterns, and the priority of an event that arrives together with a flag clear.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_mode_e;

   localparam int unsigned STAMP_FIELDS = 6;
endpackage

// File: rtl/evt_sync_filter.sv
module evt_sync_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_i,
   input  logic [FILT_W-1:0] filt_len_i,
   output logic              level_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic [FILT_W-1:0]      cnt_q;
   logic                   level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   // level follows the synchronized input once it has differed for filt_len+1 cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         level_q <= 1'b0;
      end else if (synced == level_q) begin
         cnt_q <= '0;
      end else if (cnt_q >= filt_len_i) begin
         level_q <= synced;
         cnt_q   <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign level_o = level_q;
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect
   import evt_stamp_pkg::*;
#(
   parameter edge_mode_e EDGE_MODE = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   generate
      if (EDGE_MODE == EDGE_RISE) begin : g_rise
         assign pulse_o = level_i & ~prev_q;
      end else if (EDGE_MODE == EDGE_FALL) begin : g_fall
         assign pulse_o = ~level_i & prev_q;
      end else begin : g_both
         assign pulse_o = level_i ^ prev_q;
      end
   endgenerate
endmodule

// File: rtl/evt_stamp_regs.sv
module evt_stamp_regs #(
   parameter int unsigned TIME_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              cap_en_i,
   input  logic              flag_clr_i,
   input  logic [TIME_W-1:0] live_time_i,
   input  logic              vlow_i,
   input  logic              vdet_i,
   output logic [TIME_W-1:0] cap_time_o,
   output logic              cap_vlow_o,
   output logic              cap_vdet_o,
   output logic              flag_o
);
   logic              flag_q;
   logic [TIME_W-1:0] time_q;
   logic              vlow_q;
   logic              vdet_q;
   logic              load;

   // an event may capture when the flag is free or is being cleared this cycle
   assign load = evt_i & cap_en_i & (~flag_q | flag_clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         time_q <= '0;
         vlow_q <= 1'b0;
         vdet_q <= 1'b0;
      end else begin
         flag_q <= evt_i | (flag_q & ~flag_clr_i);
         if (load) begin
            time_q <= live_time_i;
            vlow_q <= vlow_i;
            vdet_q <= vdet_i;
         end
      end
   end

   assign cap_time_o = time_q;
   assign cap_vlow_o = vlow_q;
   assign cap_vdet_o = vdet_q;
   assign flag_o     = flag_q;
endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture
   import evt_stamp_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_W      = 4,
   parameter int unsigned FIELD_W     = 8,
   parameter edge_mode_e  EDGE_MODE   = EDGE_RISE,
   localparam int unsigned TIME_W     = FIELD_W * STAMP_FIELDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_in,
   input  logic [FILT_W-1:0] filt_len,
   input  logic [TIME_W-1:0] live_time,
   input  logic              stat_vlow,
   input  logic              stat_vdet,
   input  logic              wr_cap_en,
   input  logic              cap_en_val,
   input  logic              wr_irq_en,
   input  logic              irq_en_val,
   input  logic              flag_clr,
   output logic [TIME_W-1:0] cap_time,
   output logic              cap_vlow,
   output logic              cap_vdet,
   output logic              evt_flag,
   output logic              irq_pull_low
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_W < 1) begin : g_bad_filt
         $error("FILT_W must be at least 1");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("FIELD_W must be at least 1");
      end
   endgenerate

   logic evt_level;
   logic evt_pulse;
   logic cap_en_q;
   logic ien_q;

   evt_sync_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_W     (FILT_W)
   ) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (evt_in),
      .filt_len_i(filt_len),
      .level_o   (evt_level)
   );

   evt_edge_detect #(
      .EDGE_MODE(EDGE_MODE)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(evt_level),
      .pulse_o(evt_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en_q <= 1'b0;
         ien_q    <= 1'b0;
      end else begin
         if (wr_cap_en) cap_en_q <= cap_en_val;
         if (wr_irq_en) ien_q    <= irq_en_val;
      end
   end

   evt_stamp_regs #(
      .TIME_W(TIME_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_pulse),
      .cap_en_i   (cap_en_q),
      .flag_clr_i (flag_clr),
      .live_time_i(live_time),
      .vlow_i     (stat_vlow),
      .vdet_i     (stat_vdet),
      .cap_time_o (cap_time),
      .cap_vlow_o (cap_vlow),
      .cap_vdet_o (cap_vdet),
      .flag_o     (evt_flag)
   );

   assign irq_pull_low = evt_flag & ien_q;
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
   parameter int unsigned TIME_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic              cap_en,
   input logic              flag,
   input logic              flag_clr,
   input logic              wr_ien,
   input logic              ien_val,
   input logic              irq,
   input logic [TIME_W-1:0] cap_time
);
   a_r3_cap_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> $stable(cap_time));

   a_r4_no_cap_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(cap_time));

   a_r6_hold_first_stamp: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> $stable(cap_time));

   a_r2_flag_from_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(evt_valid));

   a_r8_clr_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !evt_valid) |=> !irq);

   a_r8_ien_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && !ien_val) |=> !irq);
endmodule

bind evt_stamp_capture evt_stamp_chk #(.TIME_W(TIME_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_valid(evt_pulse),
   .cap_en   (cap_en_q),
   .flag     (evt_flag),
   .flag_clr (flag_clr),
   .wr_ien   (wr_irq_en),
   .ien_val  (irq_en_val),
   .irq      (irq_pull_low),
   .cap_time (cap_time)
);

// File: tb/evt_stamp_capture_tb.sv
module evt_stamp_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        evt_in;
   logic [3:0]  filt_len;
   logic [47:0] live_time;
   logic        stat_vlow, stat_vdet;
   logic        wr_cap_en, cap_en_val, wr_irq_en, irq_en_val, flag_clr;
   logic [47:0] cap_time;
   logic        cap_vlow, cap_vdet, evt_flag, irq_pull_low;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   evt_stamp_capture dut_i (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .filt_len(filt_len),
      .live_time(live_time), .stat_vlow(stat_vlow), .stat_vdet(stat_vdet),
      .wr_cap_en(wr_cap_en), .cap_en_val(cap_en_val),
      .wr_irq_en(wr_irq_en), .irq_en_val(irq_en_val), .flag_clr(flag_clr),
      .cap_time(cap_time), .cap_vlow(cap_vlow), .cap_vdet(cap_vdet),
      .evt_flag(evt_flag), .irq_pull_low(irq_pull_low)
   );

   localparam logic [47:0] T_VEC [0:3] = '{
      48'h25_12_31_23_59_58, 48'h00_01_01_00_00_00,
      48'h99_07_15_12_34_56, 48'h42_A5_5A_C3_3C_0F };
   localparam logic [1:0]  S_VEC [0:3] = '{2'b10, 2'b01, 2'b11, 2'b00};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_cap_en(input logic v);
      @(negedge clk); wr_cap_en = 1'b1; cap_en_val = v;
      @(negedge clk); wr_cap_en = 1'b0;
   endtask

   task automatic set_irq_en(input logic v);
      @(negedge clk); wr_irq_en = 1'b1; irq_en_val = v;
      @(negedge clk); wr_irq_en = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic pulse_evt(input int n);
      @(negedge clk); evt_in = 1'b1;
      repeat (n) @(negedge clk);
      evt_in = 1'b0;
      repeat (15) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; evt_in = 1'b0; filt_len = 4'd3; live_time = '0;
      stat_vlow = 1'b0; stat_vdet = 1'b0; wr_cap_en = 1'b0; cap_en_val = 1'b0;
      wr_irq_en = 1'b0; irq_en_val = 1'b0; flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 flag", evt_flag, 0);
      chk("R1 irq", irq_pull_low, 0);
      chk("R1 cap_time", cap_time, 0);
      chk("R1 status copies", {cap_vlow, cap_vdet}, 0);
      rst_n = 1'b1;
      // R1: enables off after reset, so an event leaves the stamp at zero and no irq
      live_time = 48'h11_11_11_11_11_11;
      pulse_evt(10);
      chk("R1 capture off after reset", cap_time, 0);
      chk("R1 irq off after reset", irq_pull_low, 0);
      clear_flag();

      set_cap_en(1'b1);
      // table of stimulus and expected stamps; R2 R3 R7
      for (int i = 0; i < 4; i++) begin
         live_time = T_VEC[i];
         {stat_vlow, stat_vdet} = S_VEC[i];
         pulse_evt(10);
         live_time = ~T_VEC[i];
         {stat_vlow, stat_vdet} = ~S_VEC[i];
         @(negedge clk);
         chk("R2 flag set", evt_flag, 1);
         chk("R3 stamp", cap_time, T_VEC[i]);
         chk("R3 status copies", {cap_vlow, cap_vdet}, S_VEC[i]);
         chk("R7 irq held off", irq_pull_low, 0);
         clear_flag();
         chk("R8 flag cleared", evt_flag, 0);
      end

      // R5 glitch shorter than filter
      live_time = 48'h01_02_03_04_05_06;
      pulse_evt(2);
      chk("R5 glitch rejected", evt_flag, 0);
      chk("R5 stamp unchanged", cap_time, T_VEC[3]);

      // R4 capture disabled
      set_cap_en(1'b0);
      pulse_evt(10);
      chk("R4 flag still set", evt_flag, 1);
      chk("R4 stamp unchanged", cap_time, T_VEC[3]);
      clear_flag();
      set_cap_en(1'b1);

      // R6 first stamp kept
      live_time = 48'hAA_AA_AA_AA_AA_AA;
      pulse_evt(10);
      live_time = 48'hBB_BB_BB_BB_BB_BB;
      pulse_evt(10);
      chk("R6 first stamp kept", cap_time, 48'hAA_AA_AA_AA_AA_AA);
      chk("R6 flag", evt_flag, 1);

      // R7 R8 interrupt path
      set_irq_en(1'b1);
      chk("R7 irq asserted", irq_pull_low, 1);
      @(negedge clk); wr_irq_en = 1'b1; irq_en_val = 1'b0;
      @(negedge clk); wr_irq_en = 1'b0;
      chk("R8 ien off releases", irq_pull_low, 0);
      set_irq_en(1'b1);
      chk("R7 irq again", irq_pull_low, 1);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk("R8 clear releases irq", irq_pull_low, 0);
      chk("R8 flag", evt_flag, 0);

      // R9 event coincides with clear (filt_len=3: pulse at 7th edge after pin change)
      live_time = 48'hCC_CC_CC_CC_CC_CC;
      pulse_evt(10);
      live_time = 48'hDD_DD_DD_DD_DD_DD;
      @(negedge clk); evt_in = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk("R9 new stamp", cap_time, 48'hDD_DD_DD_DD_DD_DD);
      chk("R9 flag kept", evt_flag, 1);
      chk("R9 irq", irq_pull_low, 1);

      // R10 falling edge ignored
      repeat (5) @(negedge clk);
      clear_flag();
      evt_in = 1'b0;
      repeat (15) @(negedge clk);
      chk("R10 fall ignored", evt_flag, 0);
      chk("R10 stamp unchanged", cap_time, 48'hDD_DD_DD_DD_DD_DD);

      // R2 exact latency with filt_len = 0
      filt_len = 4'd0;
      @(negedge clk); evt_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2 not yet after 3 edges", evt_flag, 0);
      @(negedge clk);
      chk("R2 set after 4 edges", evt_flag, 1);

      finish_run();
   end
endmodule